// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight ownership flags that two independent ports, called left and right, use to reserve shared resources. Each port has its own semaphore select (active low), a RAM chip enable that must be inactive for a semaphore access, a read/write strobe, an address bus and a pair of data buses. A port asks for a flag by writing a data word with bit 0 clear. It gives the flag up by writing bit 0 set. It then reads the flag back to learn whether it holds it.

Each side has its own view of a flag. A port reads all zeros when it owns the flag and all ones otherwise. A request made while the other side holds the flag is remembered. That request is granted on the same clock edge that applies the owner's release, so a waiting side never has to poll to win. When both ports ask for a free flag on the same edge, the left port gets it and the right request waits as pending. Read data is registered at the access edge and holds until that port makes its next read.

Top module: `semBank`

## Requirements
- R1: Only address bits 2:0 choose the flag. All higher address bits have no effect on any access.
- R2: On a write only data bit 0 counts. Bit 0 = 0 requests the flag and bit 0 = 1 releases it. The other data bits are ignored.
- R3: After a port requests a free flag, that port reads all zeros (owner) and the other port reads all ones. The two ports never own the same flag at once.
- R4: A held flag changes only through its owner. A request from the other side does not take it. When the owner releases and nothing is pending, both ports read all ones.
- R5: If the non-owner requested while the flag was held, it becomes owner on the edge that applies the owner's release.
- R6: A read returns the flag state on every data bit, so the read data is always all zeros or all ones.
- R7: A read is captured in the port's read register on the clock edge of the access. It reflects the state before that edge and holds until the port's next read. A write from the other port on the same edge does not alter it.
- R8: When both ports request the same free flag on the same edge, the left port wins and the right request stays pending.
- R9: A non-owner that writes 1 cancels only its own pending request. The owner keeps the flag.
- R10: Reset frees all flags, clears all pending requests and sets both read registers to all ones.
- R11: An access counts only when the semaphore select is low and the RAM chip enable is high. Otherwise the port's inputs are ignored.
- R12: The flags are independent. An operation on one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lSelN | input | 1 | Left semaphore select, active low |
| lCeN | input | 1 | Left RAM chip enable, active low; must be high for a semaphore access |
| lWrN | input | 1 | Left write strobe, low = write, high = read |
| lAddr | input | ADDR_W (13) | Left address; bits 2:0 pick the flag |
| lWrData | input | DATA_W (9) | Left write data; bit 0 used |
| lRdData | output | DATA_W (9) | Left registered read data |
| rSelN | input | 1 | Right semaphore select, active low |
| rCeN | input | 1 | Right RAM chip enable, active low; must be high for a semaphore access |
| rWrN | input | 1 | Right write strobe, low = write, high = read |
| rAddr | input | ADDR_W (13) | Right address; bits 2:0 pick the flag |
| rWrData | input | DATA_W (9) | Right write data; bit 0 used |
| rRdData | output | DATA_W (9) | Right registered read data |

## Verification
The bench targets three cases.

The first is handover. A design that forgets a pending request leaves the flag free after the owner releases, and the waiting side reads ones when it should read zeros.

The second is the same-edge tie. A design that grants both sides breaks exclusivity. A design that drops the loser's request frees the flag on release instead of passing it to the right port.

The third is a non-owner writing 1. A design that treats this write as a release strips the owner of the flag. The bench also checks these cases:
- a read on the same edge as the other port's request, to show that the pre-edge state is captured;
- accesses made with the chip enable low, which must be ignored;
- writes whose upper data and address bits disagree with bit 0 and bits 2:0, which show up any decode that uses the wrong bits.

// File: rtl/semPkg.sv
package semPkg;
  localparam int SEM_COUNT = 8;
  localparam int SEM_IDX_W = $clog2(SEM_COUNT);

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownState_e;

  typedef struct packed {
    logic [SEM_COUNT-1:0] setL;
    logic [SEM_COUNT-1:0] clrL;
    logic [SEM_COUNT-1:0] setR;
    logic [SEM_COUNT-1:0] clrR;
    logic                 rdL;
    logic                 rdR;
    logic [SEM_IDX_W-1:0] idxL;
    logic [SEM_IDX_W-1:0] idxR;
  } semStrobe_t;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input  logic              lSelN,
  input  logic              lCeN,
  input  logic              lWrN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic              rSelN,
  input  logic              rCeN,
  input  logic              rWrN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output semStrobe_t        strobe
);
  localparam logic [SEM_COUNT-1:0] ONE_HOT_BASE = SEM_COUNT'(1);

  logic lAcc, rAcc;
  logic lWr, rWr;
  logic [SEM_IDX_W-1:0] lIdx, rIdx;
  logic [SEM_COUNT-1:0] lSel, rSel;

  // An access needs the semaphore select low and the RAM enable idle.
  assign lAcc = !lSelN && lCeN;
  assign rAcc = !rSelN && rCeN;
  assign lWr  = lAcc && !lWrN;
  assign rWr  = rAcc && !rWrN;
  assign lIdx = lAddr[SEM_IDX_W-1:0];
  assign rIdx = rAddr[SEM_IDX_W-1:0];
  assign lSel = ONE_HOT_BASE << lIdx;
  assign rSel = ONE_HOT_BASE << rIdx;

  always_comb begin
    strobe      = '0;
    strobe.idxL = lIdx;
    strobe.idxR = rIdx;
    strobe.rdL  = lAcc && lWrN;
    strobe.rdR  = rAcc && rWrN;
    if (lWr) begin
      if (lWrData[0]) strobe.clrL = lSel;
      else            strobe.setL = lSel;
    end
    if (rWr) begin
      if (rWrData[0]) strobe.clrR = rSel;
      else            strobe.setR = rSel;
    end
  end
endmodule

// File: rtl/semCell.sv
module semCell
  import semPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic setL,
  input  logic clrL,
  input  logic setR,
  input  logic clrR,
  output logic ownL,
  output logic ownR
);
  ownState_e owner, ownerNext;
  logic reqL, reqR, reqLNext, reqRNext;

  always_comb begin
    reqLNext = setL ? 1'b1 : (clrL ? 1'b0 : reqL);
    reqRNext = setR ? 1'b1 : (clrR ? 1'b0 : reqR);
    ownerNext = owner;
    unique case (owner)
      OWN_NONE: begin
        // Left is checked first: it wins a same-edge tie.
        if (reqLNext)      ownerNext = OWN_LEFT;
        else if (reqRNext) ownerNext = OWN_RIGHT;
      end
      OWN_LEFT: begin
        if (!reqLNext) ownerNext = reqRNext ? OWN_RIGHT : OWN_NONE;
      end
      OWN_RIGHT: begin
        if (!reqRNext) ownerNext = reqLNext ? OWN_LEFT : OWN_NONE;
      end
      default: ownerNext = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner <= OWN_NONE;
      reqL  <= 1'b0;
      reqR  <= 1'b0;
    end else begin
      owner <= ownerNext;
      reqL  <= reqLNext;
      reqR  <= reqRNext;
    end
  end

  assign ownL = (owner == OWN_LEFT);
  assign ownR = (owner == OWN_RIGHT);
endmodule

// File: rtl/semData.sv
module semData
  import semPkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  semStrobe_t           strobe,
  output logic [SEM_COUNT-1:0] ownL,
  output logic [SEM_COUNT-1:0] ownR,
  output logic [DATA_W-1:0]    lRdData,
  output logic [DATA_W-1:0]    rRdData
);
  for (genvar g = 0; g < SEM_COUNT; g++) begin : g_cell
    semCell u_cell (
      .clk  (clk),
      .rstN (rstN),
      .setL (strobe.setL[g]),
      .clrL (strobe.clrL[g]),
      .setR (strobe.setR[g]),
      .clrR (strobe.clrR[g]),
      .ownL (ownL[g]),
      .ownR (ownR[g])
    );
  end

  // Each read register takes the pre-edge state and then holds it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdData <= '1;
      rRdData <= '1;
    end else begin
      if (strobe.rdL) lRdData <= {DATA_W{~ownL[strobe.idxL]}};
      if (strobe.rdR) rRdData <= {DATA_W{~ownR[strobe.idxR]}};
    end
  end
endmodule

// File: rtl/semBank.sv
module semBank
  import semPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSelN,
  input  logic              lCeN,
  input  logic              lWrN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rSelN,
  input  logic              rCeN,
  input  logic              rWrN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);
  semStrobe_t strobe;
  logic [SEM_COUNT-1:0] ownL, ownR;

  semCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .lSelN   (lSelN),
    .lCeN    (lCeN),
    .lWrN    (lWrN),
    .lAddr   (lAddr),
    .lWrData (lWrData),
    .rSelN   (rSelN),
    .rCeN    (rCeN),
    .rWrN    (rWrN),
    .rAddr   (rAddr),
    .rWrData (rWrData),
    .strobe  (strobe)
  );

  semData #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ownL    (ownL),
    .ownR    (ownR),
    .lRdData (lRdData),
    .rRdData (rRdData)
  );
endmodule

// File: rtl/semBankChk.sv
module semBankChk
  import semPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lSelN,
  input logic                 lCeN,
  input logic                 lWrN,
  input logic [ADDR_W-1:0]    lAddr,
  input logic [DATA_W-1:0]    lWrData,
  input logic [DATA_W-1:0]    lRdData,
  input logic                 rSelN,
  input logic                 rCeN,
  input logic                 rWrN,
  input logic [ADDR_W-1:0]    rAddr,
  input logic [DATA_W-1:0]    rWrData,
  input logic [DATA_W-1:0]    rRdData,
  input logic [SEM_COUNT-1:0] ownL,
  input logic [SEM_COUNT-1:0] ownR
);
  logic lAcc, rAcc, lReq, rReq;
  logic [SEM_IDX_W-1:0] lIdx, rIdx;
  logic [SEM_COUNT-1:0] relL, relR;

  assign lAcc = !lSelN && lCeN;
  assign rAcc = !rSelN && rCeN;
  assign lIdx = lAddr[SEM_IDX_W-1:0];
  assign rIdx = rAddr[SEM_IDX_W-1:0];
  assign lReq = lAcc && !lWrN && !lWrData[0];
  assign rReq = rAcc && !rWrN && !rWrData[0];
  assign relL = (lAcc && !lWrN && lWrData[0]) ? (SEM_COUNT'(1) << lIdx) : '0;
  assign relR = (rAcc && !rWrN && rWrData[0]) ? (SEM_COUNT'(1) << rIdx) : '0;

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (ownL & ownR) == '0);

  a_r6_uniform_l: assert property (@(posedge clk) disable iff (!rstN)
    (lRdData == '0) || (lRdData == '1));

  a_r6_uniform_r: assert property (@(posedge clk) disable iff (!rstN)
    (rRdData == '0) || (rRdData == '1));

  a_r7_hold_l: assert property (@(posedge clk) disable iff (!rstN)
    !(lAcc && lWrN) |=> $stable(lRdData));

  a_r11_hold_r: assert property (@(posedge clk) disable iff (!rstN)
    !(rAcc && rWrN) |=> $stable(rRdData));

  a_r4_keep_l: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(ownL) & ~$past(relL) & ~ownL) == '0));

  a_r4_keep_r: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(ownR) & ~$past(relR) & ~ownR) == '0));

  a_r8_tie: assert property (@(posedge clk) disable iff (!rstN)
    (lReq && rReq && (lIdx == rIdx) && !ownL[lIdx] && !ownR[lIdx])
      |=> ownL[$past(lIdx)]);
endmodule

bind semBank semBankChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .lSelN   (lSelN),
  .lCeN    (lCeN),
  .lWrN    (lWrN),
  .lAddr   (lAddr),
  .lWrData (lWrData),
  .lRdData (lRdData),
  .rSelN   (rSelN),
  .rCeN    (rCeN),
  .rWrN    (rWrN),
  .rAddr   (rAddr),
  .rWrData (rWrData),
  .rRdData (rRdData),
  .ownL    (ownL),
  .ownR    (ownR)
);

// File: tb/test_semBank.sv
module test_semBank;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 9;
  localparam logic [DATA_W-1:0] ONES  = '1;
  localparam logic [DATA_W-1:0] ZEROS = '0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSelN = 1'b1, lCeN = 1'b1, lWrN = 1'b1;
  logic rSelN = 1'b1, rCeN = 1'b1, rWrN = 1'b1;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic [DATA_W-1:0] lWrData = '0, rWrData = '0;
  logic [DATA_W-1:0] lRdData, rRdData;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  semBank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_semBank (.*);

  // Ops: 0 idle, 1 read, 2 write bit0=0 (request), 3 write bit0=1 (release).
  // Fields {lOp, lIdx, rOp, rIdx, expL, expR}; exp 1 = all ones, 0 = all zeros.
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    {2'd2, 3'd0, 2'd1, 3'd0, 1'b1, 1'b1},  // R7 right read same edge as left request
    {2'd1, 3'd0, 2'd1, 3'd0, 1'b0, 1'b1},  // R3
    {2'd0, 3'd0, 2'd2, 3'd0, 1'b0, 1'b1},  // R5 right posts pending
    {2'd1, 3'd0, 2'd1, 3'd0, 1'b0, 1'b1},  // R4 no steal
    {2'd3, 3'd0, 2'd0, 3'd0, 1'b0, 1'b1},  // R5 left releases
    {2'd1, 3'd0, 2'd1, 3'd0, 1'b1, 1'b0},  // R5 handover
    {2'd0, 3'd0, 2'd3, 3'd0, 1'b1, 1'b0},  // R4 owner release
    {2'd1, 3'd0, 2'd1, 3'd0, 1'b1, 1'b1},  // R4 both free
    {2'd2, 3'd3, 2'd2, 3'd3, 1'b1, 1'b1},  // R8 tie
    {2'd1, 3'd3, 2'd1, 3'd3, 1'b0, 1'b1},  // R8 left wins
    {2'd3, 3'd3, 2'd0, 3'd0, 1'b0, 1'b1},  // R8 left releases
    {2'd1, 3'd3, 2'd1, 3'd3, 1'b1, 1'b0},  // R8 right pending granted
    {2'd0, 3'd0, 2'd2, 3'd5, 1'b1, 1'b0},  // R9 right takes 5
    {2'd2, 3'd5, 2'd0, 3'd0, 1'b1, 1'b0},  // R9 left pending
    {2'd3, 3'd5, 2'd0, 3'd0, 1'b1, 1'b0},  // R9 left cancels
    {2'd0, 3'd0, 2'd3, 3'd5, 1'b1, 1'b0},  // R9 right releases
    {2'd1, 3'd5, 2'd1, 3'd5, 1'b1, 1'b1},  // R9 nothing handed over
    {2'd1, 3'd3, 2'd1, 3'd3, 1'b1, 1'b0},  // R12 flag 3 untouched
    {2'd0, 3'd0, 2'd3, 3'd3, 1'b1, 1'b0},  // R1 R2 release via upper-bit noise
    {2'd1, 3'd3, 2'd1, 3'd3, 1'b1, 1'b1}   // R12
  };

  task automatic check(input string req, input string port,
                       input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, port, got, exp);
    end
  endtask

  // Drives one port's inputs for the coming edge; upper address bits get noise (R1).
  task automatic setPort(input bit left, input logic [1:0] op, input logic [2:0] idx,
                         input logic ce, input logic [ADDR_W-4:0] noise);
    logic sel, wr;
    logic [DATA_W-1:0] dat;
    sel = (op == 2'd0);
    wr  = !op[1];
    // R2: request word has upper bits set, release word has them clear.
    dat = (op == 2'd2) ? {{(DATA_W-1){1'b1}}, 1'b0} : DATA_W'(1);
    if (left) begin
      lSelN = sel; lCeN = ce; lWrN = wr; lAddr = {noise, idx}; lWrData = dat;
    end else begin
      rSelN = sel; rCeN = ce; rWrN = wr; rAddr = {noise, idx}; rWrData = dat;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleBoth();
    setPort(1'b1, 2'd0, 3'd0, 1'b1, '0);
    setPort(1'b0, 2'd0, 3'd0, 1'b1, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "left reset", lRdData, ONES);
    check("R10", "right reset", rRdData, ONES);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      v = VEC[i];
      setPort(1'b1, v[11:10], v[9:7], 1'b1, (ADDR_W-3)'(i * 37 + 5));
      setPort(1'b0, v[6:5], v[4:2], 1'b1, (ADDR_W-3)'(i * 91 + 3));
      tick();
      check($sformatf("vec%0d", i), "left", lRdData, v[1] ? ONES : ZEROS);
      check($sformatf("vec%0d", i), "right", rRdData, v[0] ? ONES : ZEROS);
    end

    // R11: request with chip enable low is ignored.
    idleBoth();
    setPort(1'b0, 2'd2, 3'd2, 1'b0, '0);
    tick();
    setPort(1'b0, 2'd0, 3'd0, 1'b1, '0);
    setPort(1'b1, 2'd2, 3'd2, 1'b1, '0);
    tick();
    setPort(1'b1, 2'd1, 3'd2, 1'b1, '0);
    setPort(1'b0, 2'd1, 3'd2, 1'b1, '0);
    tick();
    check("R11", "left owns 2", lRdData, ZEROS);
    check("R11", "right ignored", rRdData, ONES);
    // R11: left read with enable low must not refresh left register.
    setPort(1'b1, 2'd3, 3'd2, 1'b1, '0);
    setPort(1'b0, 2'd0, 3'd0, 1'b1, '0);
    tick();
    setPort(1'b1, 2'd1, 3'd2, 1'b0, '0);
    tick();
    check("R11", "left read ignored", lRdData, ZEROS);
    setPort(1'b1, 2'd1, 3'd2, 1'b1, '0);
    tick();
    check("R11", "left read valid", lRdData, ONES);

    // R10: mid-run reset clears ownership and pending.
    setPort(1'b0, 2'd2, 3'd6, 1'b1, '0);
    setPort(1'b1, 2'd2, 3'd6, 1'b1, '0);
    tick();
    idleBoth();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    setPort(1'b1, 2'd1, 3'd6, 1'b1, '0);
    setPort(1'b0, 2'd1, 3'd6, 1'b1, '0);
    tick();
    check("R10", "left after reset", lRdData, ONES);
    check("R10", "right after reset", rRdData, ONES);
    setPort(1'b1, 2'd0, 3'd0, 1'b1, '0);
    tick();
    setPort(1'b1, 2'd1, 3'd6, 1'b1, '0);
    setPort(1'b0, 2'd3, 3'd6, 1'b1, '0);
    tick();
    check("R10", "no stale pending", lRdData, ONES);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule